// File: doc/BRIEF.md
# Register Specifier Redirection Map Table

This block stands in front of a sixteen-entry architected register file and decides, for every access, whether the access goes to that file or to one of five small custom register structures. Examples of such structures are queues, stacks and circular buffers. A table with one entry per architected specifier is consulted combinationally on both read ports and on the write port. A specifier with no valid entry is routed to the ordinary register file. A specifier with a valid entry is steered to the structure named in that entry, together with the entry's configuration field. The 4-bit specifier encoding is identical for both destinations, so no operand field grows.

A single command installs or removes an entry. The command carries a specifier, a structure index, a configuration field and a map/unmap flag, and it takes effect at the next clock edge. All pins are plain control signals. The block carries no data and has no streaming interface, so it has no valid/ready back-pressure. Every command presented with `cmd_en` high is accepted in that cycle.

Top module: `regmap_redirect`

## Requirements
- R1: After reset, and after any later reset, every specifier is unmapped, so every enabled access routes to the register file.
- R2: An enabled access to an unmapped specifier drives its `*_rf_en` high, its `*_st_sel` to zero and its `*_cfg` to zero.
- R3: An enabled access to a mapped specifier drives `*_rf_en` low, drives `*_st_sel` one-hot with bit (index-1) set, and drives `*_cfg` with the stored configuration. This holds in the same cycle on read port 0, read port 1 and the write port.
- R4: A command with `cmd_en`=1, `cmd_map`=1 and `cmd_sidx` in 1..5 installs that entry. Index 1 selects structure bit 0 and index 5 selects bit 4. Accesses see the new entry from the next cycle on.
- R5: All sixteen specifiers (4-bit codes 0..15) hold independent entries, and the same code addresses the file or the structure.
- R6: When a command and an access name the same specifier in the same cycle, the access uses the mapping held before the command.
- R7: Mapping an already mapped specifier overwrites its index and configuration.
- R8: A command with `cmd_map`=0 clears the entry of `cmd_spec`. Unmapping an unmapped specifier changes no entry.
- R9: A map command whose `cmd_sidx` is 0 or greater than 5 is ignored, and the entry keeps its previous contents.
- R10: A port whose enable is low drives `*_rf_en`, `*_st_sel` and `*_cfg` all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Map/unmap command strobe |
| cmd_map | input | 1 | 1 = map, 0 = unmap |
| cmd_spec | input | 4 | Specifier the command targets |
| cmd_sidx | input | 3 | Structure index, 1..5 |
| cmd_cfg | input | 4 | Configuration field stored with the entry |
| ra_en | input | 1 | Read port 0 access enable |
| ra_spec | input | 4 | Read port 0 specifier |
| ra_rf_en | output | 1 | Read port 0 goes to register file |
| ra_st_sel | output | 5 | Read port 0 structure select, one-hot |
| ra_cfg | output | 4 | Read port 0 structure configuration |
| rb_en | input | 1 | Read port 1 access enable |
| rb_spec | input | 4 | Read port 1 specifier |
| rb_rf_en | output | 1 | Read port 1 goes to register file |
| rb_st_sel | output | 5 | Read port 1 structure select, one-hot |
| rb_cfg | output | 4 | Read port 1 structure configuration |
| wr_en | input | 1 | Write port access enable |
| wr_spec | input | 4 | Write port specifier |
| wr_rf_en | output | 1 | Write goes to register file |
| wr_st_sel | output | 5 | Write structure select, one-hot |
| wr_cfg | output | 4 | Write structure configuration |

## Verification
The bench reads a specifier in the same cycle that a command remaps it. A design that forwards the command would steer that access to the new structure one cycle early. The bench also remaps an entry that is already mapped, and unmaps one that was never mapped. A design that set or cleared the wrong entry would disturb neighbouring specifiers, which the bench sees at the ports. Out-of-range structure indices are issued as well. A design that accepted them would either raise no select bit at all while leaving `rf_en` low, or it would corrupt a live entry. A sweep over all sixteen codes then exposes any decode that aliases specifiers or gets the index-to-bit offset wrong.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  parameter int SIDX_W = 3;
  parameter int CFG_W  = 4;

  typedef struct packed {
    logic              vld;
    logic [SIDX_W-1:0] sidx;
    logic [CFG_W-1:0]  cfg;
  } map_entry_t;
endpackage

// File: rtl/regmap_table.sv
module regmap_table
  import regmap_pkg::*;
#(
  parameter int NUM_ARCH   = 16,
  parameter int NUM_STRUCT = 5,
  localparam int SPEC_W    = $clog2(NUM_ARCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_en,
  input  logic                      cmd_map,
  input  logic [SPEC_W-1:0]         cmd_spec,
  input  logic [SIDX_W-1:0]         cmd_sidx,
  input  logic [CFG_W-1:0]          cmd_cfg,
  output map_entry_t [NUM_ARCH-1:0] tbl
);
  logic sidx_ok;
  logic do_set;
  logic do_clr;

  // index 0 and indices past the last structure name nothing
  assign sidx_ok = (cmd_sidx != '0) && (32'(cmd_sidx) <= NUM_STRUCT);
  assign do_set  = cmd_en && cmd_map && sidx_ok;
  assign do_clr  = cmd_en && !cmd_map;

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ent
    logic hit;
    assign hit = (cmd_spec == SPEC_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl[i] <= '0;
      end else if (hit && do_set) begin
        tbl[i].vld  <= 1'b1;
        tbl[i].sidx <= cmd_sidx;
        tbl[i].cfg  <= cmd_cfg;
      end else if (hit && do_clr) begin
        tbl[i].vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regmap_lookup.sv
module regmap_lookup
  import regmap_pkg::*;
#(
  parameter int NUM_ARCH   = 16,
  parameter int NUM_STRUCT = 5,
  localparam int SPEC_W    = $clog2(NUM_ARCH)
) (
  input  map_entry_t [NUM_ARCH-1:0] tbl,
  input  logic                      acc_en,
  input  logic [SPEC_W-1:0]         acc_spec,
  output logic                      rf_en,
  output logic [NUM_STRUCT-1:0]     st_sel,
  output logic [CFG_W-1:0]          cfg
);
  map_entry_t ent;
  logic       use_st;

  assign ent    = tbl[acc_spec];
  assign use_st = acc_en && ent.vld;
  assign rf_en  = acc_en && !ent.vld;
  assign cfg    = use_st ? ent.cfg : '0;

  for (genvar s = 0; s < NUM_STRUCT; s++) begin : g_sel
    assign st_sel[s] = use_st && (ent.sidx == SIDX_W'(s + 1));
  end
endmodule

// File: rtl/regmap_redirect.sv
module regmap_redirect
  import regmap_pkg::*;
#(
  parameter int NUM_ARCH   = 16,
  parameter int NUM_STRUCT = 5,
  localparam int SPEC_W    = $clog2(NUM_ARCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_en,
  input  logic                  cmd_map,
  input  logic [SPEC_W-1:0]     cmd_spec,
  input  logic [SIDX_W-1:0]     cmd_sidx,
  input  logic [CFG_W-1:0]      cmd_cfg,
  input  logic                  ra_en,
  input  logic [SPEC_W-1:0]     ra_spec,
  output logic                  ra_rf_en,
  output logic [NUM_STRUCT-1:0] ra_st_sel,
  output logic [CFG_W-1:0]      ra_cfg,
  input  logic                  rb_en,
  input  logic [SPEC_W-1:0]     rb_spec,
  output logic                  rb_rf_en,
  output logic [NUM_STRUCT-1:0] rb_st_sel,
  output logic [CFG_W-1:0]      rb_cfg,
  input  logic                  wr_en,
  input  logic [SPEC_W-1:0]     wr_spec,
  output logic                  wr_rf_en,
  output logic [NUM_STRUCT-1:0] wr_st_sel,
  output logic [CFG_W-1:0]      wr_cfg
);
  localparam int NPORT = 3;

  map_entry_t [NUM_ARCH-1:0] tbl;

  logic [NPORT-1:0]                 p_en;
  logic [NPORT-1:0][SPEC_W-1:0]     p_spec;
  logic [NPORT-1:0]                 p_rf;
  logic [NPORT-1:0][NUM_STRUCT-1:0] p_sel;
  logic [NPORT-1:0][CFG_W-1:0]      p_cfg;

  regmap_table #(.NUM_ARCH(NUM_ARCH), .NUM_STRUCT(NUM_STRUCT)) u_tbl (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_map(cmd_map),
    .cmd_spec(cmd_spec), .cmd_sidx(cmd_sidx), .cmd_cfg(cmd_cfg), .tbl(tbl)
  );

  assign p_en   = {wr_en, rb_en, ra_en};
  assign p_spec = {wr_spec, rb_spec, ra_spec};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    regmap_lookup #(.NUM_ARCH(NUM_ARCH), .NUM_STRUCT(NUM_STRUCT)) u_lk (
      .tbl(tbl), .acc_en(p_en[p]), .acc_spec(p_spec[p]),
      .rf_en(p_rf[p]), .st_sel(p_sel[p]), .cfg(p_cfg[p])
    );
  end

  assign ra_rf_en = p_rf[0];  assign ra_st_sel = p_sel[0];  assign ra_cfg = p_cfg[0];
  assign rb_rf_en = p_rf[1];  assign rb_st_sel = p_sel[1];  assign rb_cfg = p_cfg[1];
  assign wr_rf_en = p_rf[2];  assign wr_st_sel = p_sel[2];  assign wr_cfg = p_cfg[2];
endmodule

// File: rtl/regmap_redirect_chk.sv
module regmap_redirect_chk
  import regmap_pkg::*;
#(
  parameter int NUM_ARCH   = 16,
  parameter int NUM_STRUCT = 5,
  localparam int SPEC_W    = $clog2(NUM_ARCH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_en,
  input logic                  cmd_map,
  input logic [SPEC_W-1:0]     cmd_spec,
  input logic [SIDX_W-1:0]     cmd_sidx,
  input logic                  ra_en,
  input logic [SPEC_W-1:0]     ra_spec,
  input logic                  ra_rf_en,
  input logic [NUM_STRUCT-1:0] ra_st_sel,
  input logic [CFG_W-1:0]      ra_cfg,
  input logic                  wr_en,
  input logic [SPEC_W-1:0]     wr_spec,
  input logic                  wr_rf_en,
  input logic [NUM_STRUCT-1:0] wr_st_sel
);
  logic set_ok;
  assign set_ok = cmd_en && cmd_map && cmd_sidx != '0 && 32'(cmd_sidx) <= NUM_STRUCT;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ra_en |-> ($countones({ra_rf_en, ra_st_sel}) == 1)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ra_en |-> (!ra_rf_en && ra_st_sel == '0 && ra_cfg == '0)); // R10

  AST_MAP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> (!(ra_en && ra_spec == $past(cmd_spec))
               || ra_st_sel == (NUM_STRUCT'(1) << ($past(cmd_sidx) - 1'b1)))); // R4

  AST_UNMAP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_map) |=> (!(wr_en && wr_spec == $past(cmd_spec)) || wr_rf_en)); // R8

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && wr_en) |-> (wr_rf_en && wr_st_sel == '0)); // R1
endmodule

bind regmap_redirect regmap_redirect_chk #(.NUM_ARCH(NUM_ARCH), .NUM_STRUCT(NUM_STRUCT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_map(cmd_map),
  .cmd_spec(cmd_spec), .cmd_sidx(cmd_sidx),
  .ra_en(ra_en), .ra_spec(ra_spec), .ra_rf_en(ra_rf_en),
  .ra_st_sel(ra_st_sel), .ra_cfg(ra_cfg),
  .wr_en(wr_en), .wr_spec(wr_spec), .wr_rf_en(wr_rf_en), .wr_st_sel(wr_st_sel)
);

// File: tb/regmap_redirect_test.sv
`timescale 1ns/1ps
module regmap_redirect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_en = 0, cmd_map = 0;
  logic [3:0] cmd_spec = 0, cmd_cfg = 0;
  logic [2:0] cmd_sidx = 0;
  logic ra_en = 0, rb_en = 0, wr_en = 0;
  logic [3:0] ra_spec = 0, rb_spec = 0, wr_spec = 0;
  logic ra_rf_en, rb_rf_en, wr_rf_en;
  logic [4:0] ra_st_sel, rb_st_sel, wr_st_sel;
  logic [3:0] ra_cfg, rb_cfg, wr_cfg;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  regmap_redirect uut (.*);

  localparam logic [9:0] EXP_RF = 10'b1_00000_0000;
  localparam logic [9:0] EXP_IDLE = 10'b0;

  function automatic logic [9:0] exp_st(input int sidx, input logic [3:0] cfg);
    return {1'b0, 5'(5'b1 << (sidx - 1)), cfg};
  endfunction

  task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic cmd(input logic m, input int spec, input int sidx, input int cfg);
    @(negedge clk);
    cmd_en = 1; cmd_map = m; cmd_spec = 4'(spec); cmd_sidx = 3'(sidx); cmd_cfg = 4'(cfg);
    @(negedge clk);
    cmd_en = 0;
  endtask

  task automatic look(input int a, input int b, input int w);
    ra_en = 1; rb_en = 1; wr_en = 1;
    ra_spec = 4'(a); rb_spec = 4'(b); wr_spec = 4'(w);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; #1; rst_n = 1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) begin
      look(i, 15 - i, i);
      chk("R1 read after reset", {ra_rf_en, ra_st_sel, ra_cfg}, EXP_RF);
      chk("R2 write unmapped", {wr_rf_en, wr_st_sel, wr_cfg}, EXP_RF);
    end
  endtask

  task automatic t_map_basic();
    cmd(1, 3, 2, 5);
    look(3, 4, 3);
    chk("R3 R4 read0 mapped Q2", {ra_rf_en, ra_st_sel, ra_cfg}, exp_st(2, 4'd5));
    chk("R2 read1 neighbour unmapped", {rb_rf_en, rb_st_sel, rb_cfg}, EXP_RF);
    chk("R3 write mapped Q2", {wr_rf_en, wr_st_sel, wr_cfg}, exp_st(2, 4'd5));
    look(0, 3, 0);
    chk("R3 read1 mapped Q2", {rb_rf_en, rb_st_sel, rb_cfg}, exp_st(2, 4'd5));
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cmd_en = 1; cmd_map = 1; cmd_spec = 7; cmd_sidx = 4; cmd_cfg = 4'hA;
    look(7, 7, 7);
    chk("R6 access sees old entry", {ra_rf_en, ra_st_sel, ra_cfg}, EXP_RF);
    @(negedge clk);
    cmd_en = 0; #1;
    chk("R6 new entry next cycle", {ra_rf_en, ra_st_sel, ra_cfg}, exp_st(4, 4'hA));
  endtask

  task automatic t_overwrite();
    cmd(1, 3, 5, 9);
    look(3, 7, 3);
    chk("R7 overwrite index and cfg", {ra_rf_en, ra_st_sel, ra_cfg}, exp_st(5, 4'd9));
    chk("R7 other entry kept", {rb_rf_en, rb_st_sel, rb_cfg}, exp_st(4, 4'hA));
  endtask

  task automatic t_unmap();
    cmd(0, 3, 0, 0);
    look(3, 7, 3);
    chk("R8 unmap returns to file", {ra_rf_en, ra_st_sel, ra_cfg}, EXP_RF);
    chk("R8 unmap spares others", {rb_rf_en, rb_st_sel, rb_cfg}, exp_st(4, 4'hA));
    cmd(0, 9, 3, 3);
    look(9, 7, 9);
    chk("R8 unmap of unmapped", {ra_rf_en, ra_st_sel, ra_cfg}, EXP_RF);
    chk("R8 unmap of unmapped spares others", {rb_rf_en, rb_st_sel, rb_cfg}, exp_st(4, 4'hA));
  endtask

  task automatic t_bad_index();
    cmd(1, 10, 0, 1);
    look(10, 0, 10);
    chk("R9 index 0 ignored", {ra_rf_en, ra_st_sel, ra_cfg}, EXP_RF);
    cmd(1, 7, 6, 2);
    look(7, 0, 7);
    chk("R9 index 6 keeps entry", {ra_rf_en, ra_st_sel, ra_cfg}, exp_st(4, 4'hA));
    cmd(1, 7, 7, 2);
    look(7, 0, 7);
    chk("R9 index 7 keeps entry", {wr_rf_en, wr_st_sel, wr_cfg}, exp_st(4, 4'hA));
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 16; i++) cmd(1, i, (i % 5) + 1, 15 - i);
    for (int i = 0; i < 16; i++) begin
      look(i, 15 - i, i);
      chk("R5 sweep read0", {ra_rf_en, ra_st_sel, ra_cfg}, exp_st((i % 5) + 1, 4'(15 - i)));
      chk("R5 sweep read1", {rb_rf_en, rb_st_sel, rb_cfg},
          exp_st(((15 - i) % 5) + 1, 4'(i)));
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    ra_en = 0; rb_en = 0; wr_en = 0; ra_spec = 2; rb_spec = 0; wr_spec = 15; #1;
    chk("R10 read0 idle", {ra_rf_en, ra_st_sel, ra_cfg}, EXP_IDLE);
    chk("R10 read1 idle", {rb_rf_en, rb_st_sel, rb_cfg}, EXP_IDLE);
    chk("R10 write idle", {wr_rf_en, wr_st_sel, wr_cfg}, EXP_IDLE);
  endtask

  task automatic t_reset_again();
    do_reset();
    look(4, 11, 15);
    chk("R1 reset clears read0", {ra_rf_en, ra_st_sel, ra_cfg}, EXP_RF);
    chk("R1 reset clears read1", {rb_rf_en, rb_st_sel, rb_cfg}, EXP_RF);
    chk("R1 reset clears write", {wr_rf_en, wr_st_sel, wr_cfg}, EXP_RF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_map_basic();
    t_same_cycle();
    t_overwrite();
    t_unmap();
    t_bad_index();
    t_sweep();
    t_idle();
    t_reset_again();
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule